// File: doc/BRIEF.md
# Frame-Synced Serial Register Write Receiver

This block accepts register write frames sent over a serial link. The link clock is not used as a clock here. Instead, each falling edge of the serial clock arrives as a one-cycle enable pulse on the fast system clock. On every such pulse the receiver samples an active-low frame-sync line. A high-to-low transition of that line starts a frame. The 32 bits that follow on the next 32 pulses form the frame, most significant bit first. The first 16 bits carry a device select and a register number. The last 16 bits carry the value to write.

A frame is only acted on when its device select equals the local device number on `local_dev`. In that case the block raises a one-cycle write strobe and presents the register number and the data. Several receivers can then share one serial line, each with its own number. While a frame is in progress, any further activity on the frame-sync line is ignored. The sync pulse may be anywhere from one to 32 serial periods wide.

Top module: `serial_cfg_writer`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `wr_en` is 0 and `wr_reg` and `wr_data` are all zeros.
- R2: The frame-sync input is looked at only in cycles where `sclk_fall` is 1. A frame starts on such a cycle when `fsync_n` is 0 and the previous sampled value was 1. The previous sampled value resets to 1.
- R3: The 32 frame bits are taken from `sdin` on the 32 `sclk_fall` cycles that follow the start cycle, most significant bit first. Bits 31..16 form the address field and bits 15..0 form the data field.
- R4: Address field bits 15..13 are the device select. Bits 12..0 are the register number, and they are presented on `wr_reg`.
- R5: When the device select equals `local_dev`, `wr_en` is 1 for exactly one clock cycle. That cycle directly follows the cycle in which the 32nd bit is sampled. `wr_reg` and `wr_data` carry the frame's fields in that same cycle.
- R6: When the device select differs from `local_dev`, no strobe is issued, and `wr_reg` and `wr_data` keep their previous values.
- R7: A frame-sync low pulse of any width from 1 to 32 serial periods yields one correctly received frame.
- R8: A frame-sync falling edge that occurs while a frame is being received does not restart or disturb that frame.
- R9: If frame sync stays low after a frame completes, no new frame starts. A new frame needs frame sync to be sampled high and then low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_fall | input | 1 | One-cycle pulse marking a serial clock falling edge |
| fsync_n | input | 1 | Active-low frame sync |
| sdin | input | 1 | Serial write data |
| local_dev | input | 3 | Device number this receiver answers to |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_reg | output | 13 | Register number of the write |
| wr_data | output | 16 | Value to write |

## Verification
The assertions assume that `sclk_fall` is a single-cycle pulse with idle cycles between pulses. They also assume that `local_dev` does not change while a frame is in progress, and that reset is asserted from time zero. The bench meets these conditions. It raises `sclk_fall` for one cycle out of every four. It changes `fsync_n` and `sdin` only on falling system-clock edges before a pulse. It changes `local_dev` only between frames, while frame sync is held high.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int DEV_W_DEF  = 3;
  localparam int REG_W_DEF  = 13;
  localparam int DATA_W_DEF = 16;

  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_SHIFT = 1'b1
  } rx_state_t;
endpackage

// File: rtl/cfgw_sync.sv
module cfgw_sync (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic fsync_n,
  input  logic armed,
  output logic start,
  output logic fs_prev
);
  // previous sampled frame-sync level, updated on serial falling edges only
  always_ff @(posedge clk) begin
    if (rst)       fs_prev <= 1'b1;
    else if (tick) fs_prev <= fsync_n;
  end

  always_comb start = tick && armed && fs_prev && !fsync_n;
endmodule

// File: rtl/cfgw_shift.sv
module cfgw_shift
  import cfgw_pkg::*;
#(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               start,
  input  logic               sdin,
  output logic               busy,
  output logic               last,
  output logic [FRAME_W-1:0] word
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  rx_state_t          st;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-2:0] sr;

  always_comb begin
    busy = (st == RX_SHIFT);
    last = tick && busy && (cnt == LAST_IDX);
    word = {sr, sdin};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= RX_IDLE;
      cnt <= '0;
      sr  <= '0;
    end else if (tick) begin
      case (st)
        RX_IDLE: begin
          if (start) begin
            st  <= RX_SHIFT;
            cnt <= '0;
          end
        end
        RX_SHIFT: begin
          sr  <= word[FRAME_W-2:0];
          cnt <= cnt + 1'b1;
          if (cnt == LAST_IDX) st <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgw_decode.sv
module cfgw_decode #(
  parameter int DEV_W  = 3,
  parameter int REG_W  = 13,
  parameter int DATA_W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            last,
  input  logic [DEV_W+REG_W+DATA_W-1:0]   word,
  input  logic [DEV_W-1:0]                local_dev,
  output logic                            hit,
  output logic                            wr_en,
  output logic [REG_W-1:0]                wr_reg,
  output logic [DATA_W-1:0]               wr_data
);
  localparam int FRAME_W = DEV_W + REG_W + DATA_W;

  logic [DEV_W-1:0] dev_sel;

  always_comb begin
    dev_sel = word[FRAME_W-1 -: DEV_W];
    hit     = (dev_sel == local_dev);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_reg  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= last && hit;
      if (last && hit) begin
        wr_reg  <= word[DATA_W +: REG_W];
        wr_data <= word[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/serial_cfg_writer.sv
module serial_cfg_writer
  import cfgw_pkg::*;
#(
  parameter int DEV_W  = DEV_W_DEF,
  parameter int REG_W  = REG_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_fall,
  input  logic              fsync_n,
  input  logic              sdin,
  input  logic [DEV_W-1:0]  local_dev,
  output logic              wr_en,
  output logic [REG_W-1:0]  wr_reg,
  output logic [DATA_W-1:0] wr_data
);
  localparam int FRAME_W = DEV_W + REG_W + DATA_W;

  logic               start;
  logic               fs_prev;
  logic               busy;
  logic               last;
  logic               hit;
  logic [FRAME_W-1:0] word;

  cfgw_sync u_sync (
    .clk     (clk),
    .rst     (rst),
    .tick    (sclk_fall),
    .fsync_n (fsync_n),
    .armed   (!busy),
    .start   (start),
    .fs_prev (fs_prev)
  );

  cfgw_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .tick  (sclk_fall),
    .start (start),
    .sdin  (sdin),
    .busy  (busy),
    .last  (last),
    .word  (word)
  );

  cfgw_decode #(.DEV_W(DEV_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .last      (last),
    .word      (word),
    .local_dev (local_dev),
    .hit       (hit),
    .wr_en     (wr_en),
    .wr_reg    (wr_reg),
    .wr_data   (wr_data)
  );
endmodule

// File: rtl/serial_cfg_writer_chk.sv
module serial_cfg_writer_chk #(
  parameter int REG_W  = 13,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sclk_fall,
  input logic              fsync_n,
  input logic              busy,
  input logic              fs_prev,
  input logic              hit,
  input logic              wr_en,
  input logic [REG_W-1:0]  wr_reg,
  input logic [DATA_W-1:0] wr_data
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!wr_en && wr_reg == '0 && wr_data == '0));

  assert_start_sampled_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(sclk_fall && !fsync_n));

  assert_start_needs_high_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(fs_prev));

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  assert_strobe_after_tick_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(sclk_fall) && $fell(busy)));

  assert_strobe_match_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(hit));

  assert_hold_outputs_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (wr_reg == $past(wr_reg) && wr_data == $past(wr_data)));
endmodule

bind serial_cfg_writer serial_cfg_writer_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sclk_fall (sclk_fall),
  .fsync_n   (fsync_n),
  .busy      (busy),
  .fs_prev   (fs_prev),
  .hit       (hit),
  .wr_en     (wr_en),
  .wr_reg    (wr_reg),
  .wr_data   (wr_data)
);

// File: tb/serial_cfg_writer_test.sv
`timescale 1ns/1ps
module serial_cfg_writer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk_fall = 1'b0;
  logic        fsync_n = 1'b1;
  logic        sdin = 1'b0;
  logic [2:0]  local_dev = 3'd5;
  logic        wr_en;
  logic [12:0] wr_reg;
  logic [15:0] wr_data;

  int tests = 0;
  int fails = 0;
  int nstb  = 0;
  int hi_run = 0;
  int max_run = 0;
  logic [12:0] cap_reg;
  logic [15:0] cap_data;

  always #4 clk = ~clk;

  serial_cfg_writer uut (
    .clk(clk), .rst(rst), .sclk_fall(sclk_fall), .fsync_n(fsync_n),
    .sdin(sdin), .local_dev(local_dev),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data)
  );

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (wr_en) begin
      nstb++;
      hi_run++;
      if (hi_run > max_run) max_run = hi_run;
      cap_reg  = wr_reg;
      cap_data = wr_data;
    end else begin
      hi_run = 0;
    end
  end

  // {dev[3], reg[13], data[16], fs_width[6], expect_strobe[1]}
  localparam int NV = 6;
  localparam logic [38:0] VEC [NV] = '{
    {3'd5, 13'h0001, 16'hA5A5, 6'd1,  1'b1},
    {3'd5, 13'h1FFF, 16'hFFFF, 6'd32, 1'b1},
    {3'd2, 13'h0123, 16'h1234, 6'd8,  1'b0},
    {3'd5, 13'h0000, 16'h0000, 6'd16, 1'b1},
    {3'd7, 13'h0AAA, 16'h5555, 6'd1,  1'b0},
    {3'd5, 13'h1555, 16'h8001, 6'd2,  1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic fs, input logic d);
    @(negedge clk);
    fsync_n   = fs;
    sdin      = d;
    sclk_fall = 1'b1;
    @(negedge clk);
    sclk_fall = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // start tick + 32 bit ticks, optional mid-frame sync edge, optional low tail
  task automatic send(input logic [31:0] w, input int fsw, input int glitch, input int tail);
    nstb = 0;
    max_run = 0;
    for (int i = 0; i <= 32; i++) begin
      logic fs;
      fs = (i < fsw) ? 1'b0 : 1'b1;
      if (glitch > 0) fs = (i == 0 || i == glitch) ? 1'b0 : 1'b1;
      tick(fs, (i == 0) ? 1'b0 : w[32-i]);
    end
    for (int j = 0; j < tail; j++) tick(1'b0, j[0] ^ j[2]);
    tick(1'b1, 1'b0);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [12:0] exp_reg;
    logic [15:0] exp_data;
    exp_reg  = '0;
    exp_data = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(wr_en == 1'b0, "R1 wr_en in reset", 32'(wr_en), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(wr_en == 1'b0, "R1 wr_en after reset", 32'(wr_en), 0);
    check(wr_reg == '0 && wr_data == '0, "R1 outputs after reset", {3'd0, wr_reg, wr_data}, 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      logic [38:0] e;
      e = VEC[v];
      send(e[38:7], int'(e[6:1]), 0, 0);
      check(nstb == int'(e[0]), "R5/R6 strobe count", 32'(nstb), 32'(e[0]));
      if (e[0]) begin
        exp_reg  = e[35:23];
        exp_data = e[22:7];
        check(max_run == 1, "R5 strobe width", 32'(max_run), 1);
      end
      check(wr_reg == exp_reg, "R4 register field", 32'(wr_reg), 32'(exp_reg));
      check(wr_data == exp_data, "R3 data field", 32'(wr_data), 32'(exp_data));
    end

    // R8: falling sync edge in mid-frame is ignored
    send({3'd5, 13'h0F0F, 16'hC3C3}, 1, 10, 0);
    check(nstb == 1, "R8 strobes with mid-frame edge", 32'(nstb), 1);
    check(cap_reg == 13'h0F0F && cap_data == 16'hC3C3, "R8 frame intact",
          {3'd0, cap_reg, cap_data}, {3'd0, 13'h0F0F, 16'hC3C3});

    // R9: sync held low past frame end does not retrigger
    send({3'd5, 13'h0042, 16'h7E7E}, 33, 0, 40);
    check(nstb == 1, "R9 no retrigger on held low", 32'(nstb), 1);
    check(wr_data == 16'h7E7E, "R9 data", 32'(wr_data), 32'h7E7E);

    // R5: different local number selects another device
    local_dev = 3'd2;
    send({3'd2, 13'h0777, 16'h2468}, 4, 0, 0);
    check(nstb == 1 && wr_reg == 13'h0777 && wr_data == 16'h2468, "R5 new local_dev match",
          {3'd0, wr_reg, wr_data}, {3'd0, 13'h0777, 16'h2468});
    send({3'd5, 13'h0001, 16'h1111}, 1, 0, 0);
    check(nstb == 0 && wr_data == 16'h2468, "R6 old device ignored", 32'(wr_data), 32'h2468);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule